// File: doc/BRIEF.md
# One-Wire Bus Monitor Decoder

This block watches a single open-drain one-wire line without ever driving it. The line is brought into the system clock domain through a short synchronizer chain. Every slot opens with a high-to-low transition and is then judged only by how many clock cycles have passed since that transition. The time unit T (30 microseconds at normal speed) is set by the parameter `T_CLKS`, the number of system clocks in one T. All other thresholds are integer clock counts derived from it: 8T, and 2.5T rounded to the nearest count.

The monitor reports three kinds of event on single-cycle strobes. A data bit is the line level one T into a slot. A bus reset is a low period longer than 8T. A presence answer is the line level 2.5T after a reset's low period ends. The eight bits that follow each reset are collected into a command byte, least significant bit first. That byte is reported once, together with a class code that names the ROM-level command it encodes. A debug or protocol-analysis fabric can use these strobes to trace traffic on the line.

Top module: `ow_bus_monitor`

## Requirements
- R1: After the synchronous reset `rst` every strobe output is 0. `cmd_byte`, `cmd_class`, `bit_val` and `dev_present` are 0. The synchronizer treats the line as idle high, so a slot starts only on a real high-to-low transition of `ow_in`.
- R2: Each slot yields one `bit_valid` pulse of one cycle. The pulse is high T_CLKS+3 clock cycles after the first rising clock edge that sees `ow_in` low. This delay counts two synchronizer stages and one output register.
- R3: `bit_val` is the line level T_CLKS clocks into the slot. If `ow_in` stays low for L clocks, `bit_val` is 1 when L <= T_CLKS and 0 when L > T_CLKS.
- R4: After a 1 bit the monitor waits for the next falling edge. After a 0 bit it waits for the line to rise. A low period of at most 8*T_CLKS clocks produces nothing more than its bit.
- R5: A low period longer than 8*T_CLKS clocks produces its 0 bit and then one `rst_valid` pulse. A low period of exactly 8*T_CLKS clocks produces no reset.
- R6: `pres_valid` pulses exactly P25 = round(2.5*T_CLKS) cycles after `rst_valid`. No other event can trigger it. `dev_present` is 1 when the line was low at that sample and 0 when it was high.
- R7: Low pulses that begin between a reset's rising edge and its presence sample do not start a slot and produce no `bit_valid`.
- R8: The first eight bits after a reset, or after `rst`, are packed with the first bit at bit 0. `cmd_valid` pulses one cycle after the eighth `bit_valid`, with the byte on `cmd_byte`.
- R9: A reset discards a partly received byte. The next command is built only from bits that follow the reset.
- R10: `cmd_class` codes are: 0 unknown, 1 read ROM (0x33 or 0x0F), 2 skip ROM (0xCC), 3 match ROM (0x55), 4 search ROM (0xF0), 5 overdrive skip ROM (0x3C), 6 overdrive match ROM (0x69).
- R11: Bits after the command byte produce no further `cmd_valid` until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ow_in | input | 1 | Asynchronous one-wire line level |
| bit_valid | output | 1 | One-cycle strobe: a data bit was sampled |
| bit_val | output | 1 | Value of the sampled data bit |
| rst_valid | output | 1 | One-cycle strobe: a bus reset ended |
| pres_valid | output | 1 | One-cycle strobe: presence sample taken |
| dev_present | output | 1 | 1 when a device pulled the line low at the presence sample |
| cmd_valid | output | 1 | One-cycle strobe: command byte complete |
| cmd_byte | output | 8 | Assembled command byte |
| cmd_class | output | 3 | Command class code (see R10) |

## Verification
A wrong slot phase shows at the ports within one slot. It appears as a missing or extra `bit_valid`, a `bit_valid` at the wrong cycle offset, or a bit of the wrong value at the T_CLKS and T_CLKS+1 boundaries. A timer that drifts moves the 8T reset threshold or the presence sample. That is caught by the 96/97 clock boundary slots and by the fixed gap between `rst_valid` and `pres_valid`. A stale bit counter or byte register shows on the very next `cmd_valid`, as a wrong byte, a wrong class or a pulse at the wrong point in the bit stream.

// File: rtl/ow_mon_pkg.sv
package ow_mon_pkg;

  typedef enum logic [1:0] {
    SL_IDLE   = 2'd0,
    SL_SAMPLE = 2'd1,
    SL_WRISE  = 2'd2,
    SL_PRES   = 2'd3
  } slot_state_e;

  typedef enum logic [2:0] {
    CC_UNKNOWN  = 3'd0,
    CC_READ     = 3'd1,
    CC_SKIP     = 3'd2,
    CC_MATCH    = 3'd3,
    CC_SEARCH   = 3'd4,
    CC_OD_SKIP  = 3'd5,
    CC_OD_MATCH = 3'd6
  } cmd_class_e;

  localparam int NUM_CODES = 7;

  function automatic cmd_class_e classify_cmd(input logic [7:0] code);
    logic [7:0] codes [NUM_CODES];
    cmd_class_e kinds [NUM_CODES];
    cmd_class_e res;
    codes[0] = 8'h33; kinds[0] = CC_READ;
    codes[1] = 8'h0F; kinds[1] = CC_READ;
    codes[2] = 8'hCC; kinds[2] = CC_SKIP;
    codes[3] = 8'h55; kinds[3] = CC_MATCH;
    codes[4] = 8'hF0; kinds[4] = CC_SEARCH;
    codes[5] = 8'h3C; kinds[5] = CC_OD_SKIP;
    codes[6] = 8'h69; kinds[6] = CC_OD_MATCH;
    res = CC_UNKNOWN;
    for (int i = 0; i < NUM_CODES; i++) begin
      if (code == codes[i]) res = kinds[i];
    end
    return res;
  endfunction

endpackage

// File: rtl/ow_sync.sv
module ow_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level,
  output logic fall,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b1;
          else     chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b1;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b1;
    else     prev <= chain[STAGES-1];
  end

  assign level = chain[STAGES-1];
  assign fall  = prev & ~level;
  assign rise  = ~prev & level;
endmodule

// File: rtl/ow_slot_timer.sv
module ow_slot_timer
  import ow_mon_pkg::*;
#(
  parameter int T_CLKS = 1500
) (
  input  logic clk,
  input  logic rst,
  input  logic level,
  input  logic fall,
  input  logic rise,
  output logic bit_valid,
  output logic bit_val,
  output logic rst_valid,
  output logic pres_valid,
  output logic dev_present
);
  localparam int RST_CLKS  = 8 * T_CLKS;
  localparam int PRES_CLKS = (5 * T_CLKS + 1) / 2;
  localparam int CW        = $clog2(RST_CLKS + 2) + 1;
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};
  localparam logic [CW-1:0] T_CNT   = CW'(T_CLKS);
  localparam logic [CW-1:0] R_CNT   = CW'(RST_CLKS);
  localparam logic [CW-1:0] P_CNT   = CW'(PRES_CLKS);

  slot_state_e   state;
  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_inc;

  assign cnt_inc = (cnt == CNT_MAX) ? cnt : cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= SL_IDLE;
      cnt         <= '0;
      bit_valid   <= 1'b0;
      bit_val     <= 1'b0;
      rst_valid   <= 1'b0;
      pres_valid  <= 1'b0;
      dev_present <= 1'b0;
    end else begin
      bit_valid  <= 1'b0;
      rst_valid  <= 1'b0;
      pres_valid <= 1'b0;
      case (state)
        SL_IDLE: begin
          if (fall) begin
            state <= SL_SAMPLE;
            cnt   <= CW'(1);
          end
        end
        SL_SAMPLE: begin
          cnt <= cnt_inc;
          if (cnt == T_CNT) begin
            bit_valid <= 1'b1;
            bit_val   <= level;
            state     <= level ? SL_IDLE : SL_WRISE;
          end
        end
        SL_WRISE: begin
          if (rise) begin
            if (cnt > R_CNT) begin
              rst_valid <= 1'b1;
              cnt       <= CW'(1);
              state     <= SL_PRES;
            end else begin
              state <= SL_IDLE;
            end
          end else begin
            cnt <= cnt_inc;
          end
        end
        SL_PRES: begin
          cnt <= cnt_inc;
          if (cnt == P_CNT) begin
            pres_valid  <= 1'b1;
            dev_present <= ~level;
            state       <= SL_IDLE;
          end
        end
        default: state <= SL_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ow_cmd_decode.sv
module ow_cmd_decode
  import ow_mon_pkg::*;
#(
  parameter int CMD_BITS = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bit_valid,
  input  logic                bit_val,
  input  logic                rst_valid,
  output logic                cmd_valid,
  output logic [CMD_BITS-1:0] cmd_byte,
  output logic [2:0]          cmd_class
);
  localparam int BW = $clog2(CMD_BITS);

  logic                collecting;
  logic [BW-1:0]       bcnt;
  logic [CMD_BITS-1:0] shreg;
  logic [CMD_BITS-1:0] next_byte;

  always_comb begin
    next_byte       = shreg;
    next_byte[bcnt] = bit_val;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      collecting <= 1'b1;
      bcnt       <= '0;
      shreg      <= '0;
      cmd_valid  <= 1'b0;
      cmd_byte   <= '0;
      cmd_class  <= CC_UNKNOWN;
    end else begin
      cmd_valid <= 1'b0;
      if (rst_valid) begin
        collecting <= 1'b1;
        bcnt       <= '0;
        shreg      <= '0;
      end else if (bit_valid && collecting) begin
        if (bcnt == BW'(CMD_BITS - 1)) begin
          cmd_valid  <= 1'b1;
          cmd_byte   <= next_byte;
          cmd_class  <= classify_cmd(8'(next_byte));
          collecting <= 1'b0;
          bcnt       <= '0;
          shreg      <= '0;
        end else begin
          shreg <= next_byte;
          bcnt  <= bcnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ow_bus_monitor.sv
module ow_bus_monitor #(
  parameter int T_CLKS      = 1500,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ow_in,
  output logic       bit_valid,
  output logic       bit_val,
  output logic       rst_valid,
  output logic       pres_valid,
  output logic       dev_present,
  output logic       cmd_valid,
  output logic [7:0] cmd_byte,
  output logic [2:0] cmd_class
);
  logic lvl, fall, rise;

  ow_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(ow_in),
    .level(lvl), .fall(fall), .rise(rise)
  );

  ow_slot_timer #(.T_CLKS(T_CLKS)) u_slot (
    .clk(clk), .rst(rst), .level(lvl), .fall(fall), .rise(rise),
    .bit_valid(bit_valid), .bit_val(bit_val), .rst_valid(rst_valid),
    .pres_valid(pres_valid), .dev_present(dev_present)
  );

  ow_cmd_decode #(.CMD_BITS(8)) u_cmd (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_val(bit_val),
    .rst_valid(rst_valid), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .cmd_class(cmd_class)
  );
endmodule

// File: rtl/ow_bus_monitor_chk.sv
module ow_bus_monitor_chk #(
  parameter int T_CLKS = 1500
) (
  input logic       clk,
  input logic       rst,
  input logic       bit_valid,
  input logic       rst_valid,
  input logic       pres_valid,
  input logic       cmd_valid,
  input logic [7:0] cmd_byte,
  input logic [2:0] cmd_class
);
  localparam int PRES_CLKS = (5 * T_CLKS + 1) / 2;
  localparam int GW = $clog2(PRES_CLKS + 2) + 1;
  localparam logic [GW-1:0] GMAX = {GW{1'b1}};

  logic          armed;
  logic [GW-1:0] gap;
  logic [3:0]    nbits;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      gap   <= '0;
      nbits <= '0;
    end else begin
      if (rst_valid)       armed <= 1'b1;
      else if (pres_valid) armed <= 1'b0;
      if (rst_valid)         gap <= GW'(1);
      else if (gap != GMAX)  gap <= gap + 1'b1;
      if (rst_valid)                       nbits <= '0;
      else if (bit_valid && nbits != 4'hF) nbits <= nbits + 1'b1;
    end
  end

  // R2: a bit strobe lasts a single cycle
  a_r2_bit_pulse: assert property (@(posedge clk) disable iff (rst)
    bit_valid |=> !bit_valid);

  // R5: slot events never coincide
  a_r5_events_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({bit_valid, rst_valid, pres_valid}));

  // R6: presence only after a reset
  a_r6_pres_needs_reset: assert property (@(posedge clk) disable iff (rst)
    pres_valid |-> armed);

  // R6: presence sample sits at a fixed distance from the reset strobe
  a_r6_pres_delay: assert property (@(posedge clk) disable iff (rst)
    pres_valid |-> (gap == GW'(PRES_CLKS)));

  // R8: command strobe follows a bit strobe
  a_r8_cmd_after_bit: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> $past(bit_valid));

  // R11: command byte only on the eighth bit since reset
  a_r11_cmd_on_eighth: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> (nbits == 4'd8));

  // R10: skip code class
  a_r10_skip_class: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_byte == 8'hCC) |-> (cmd_class == 3'd2));
endmodule

bind ow_bus_monitor ow_bus_monitor_chk #(.T_CLKS(T_CLKS)) u_chk (
  .clk(clk), .rst(rst), .bit_valid(bit_valid), .rst_valid(rst_valid),
  .pres_valid(pres_valid), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
  .cmd_class(cmd_class)
);

// File: tb/tb_ow_bus_monitor.sv
module tb_ow_bus_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int T = 12;
  localparam int R8 = 8 * T;
  localparam int MAXEV = 4096;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ow_in = 1'b1;
  logic bit_valid, bit_val, rst_valid, pres_valid, dev_present, cmd_valid;
  logic [7:0] cmd_byte;
  logic [2:0] cmd_class;

  ow_bus_monitor #(.T_CLKS(T), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .ow_in(ow_in), .bit_valid(bit_valid),
    .bit_val(bit_val), .rst_valid(rst_valid), .pres_valid(pres_valid),
    .dev_present(dev_present), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .cmd_class(cmd_class)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int total = 0, bad = 0;
  int cyc = 0, fall_cyc = 0;
  logic [12:0] expq [MAXEV];
  int en = 0, oi = 0;
  logic e_wait = 1'b1;
  int e_cnt = 0;
  logic [7:0] e_byte = 8'h00;
  logic done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [2:0] cls_of(input logic [7:0] b);
    case (b)
      8'h33, 8'h0F: return 3'd1;
      8'hCC:        return 3'd2;
      8'h55:        return 3'd3;
      8'hF0:        return 3'd4;
      8'h3C:        return 3'd5;
      8'h69:        return 3'd6;
      default:      return 3'd0;
    endcase
  endfunction

  function automatic string req_of(input logic [1:0] ty);
    case (ty)
      2'd0: return "R3";
      2'd1: return "R5";
      2'd2: return "R6";
      default: return "R8/R10";
    endcase
  endfunction

  task automatic push(input logic [1:0] ty, input logic [2:0] c, input logic [7:0] d);
    if (en < MAXEV) begin
      expq[en] = {ty, c, d};
      en++;
    end
  endtask

  // R8 R9 R11: model of command assembly
  task automatic exp_bit(input logic b);
    push(2'd0, 3'd0, {7'd0, b});
    if (e_wait) begin
      e_byte[e_cnt] = b;
      e_cnt++;
      if (e_cnt == 8) begin
        push(2'd3, cls_of(e_byte), e_byte);
        e_wait = 1'b0;
        e_cnt = 0;
        e_byte = 8'h00;
      end
    end
  endtask

  task automatic chk(input bit ok, input string rq, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, expv);
    end
  endtask

  // drive one low period of L clocks; optional presence answer after a reset
  task automatic slot(input int L, input bit pres);
    bit is_rst;
    is_rst = (L > R8);
    exp_bit(L <= T);
    if (is_rst) begin
      push(2'd1, 3'd0, 8'd0);
      push(2'd2, 3'd0, {7'd0, pres});
      e_wait = 1'b1;
      e_cnt = 0;
      e_byte = 8'h00;
    end
    @(negedge clk);
    ow_in = 1'b0;
    fall_cyc = cyc;
    repeat (L) @(negedge clk);
    ow_in = 1'b1;
    if (is_rst && pres) begin
      repeat (T) @(negedge clk);
      ow_in = 1'b0;
      repeat (4 * T) @(negedge clk);
      ow_in = 1'b1;
    end
    repeat (3 * T) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    if (b) slot(1 + ($urandom % T), 1'b0);
    else   slot(T + 1 + ($urandom % (R8 - T)), 1'b0);
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
  endtask

  task automatic bus_reset(input bit pres);
    slot(R8 + 1 + ($urandom % (4 * T)), pres);
  endtask

  // monitor: compare observed events in order, and bit latency
  always @(negedge clk) begin
    if (!rst) begin
      if (bit_valid) begin
        // R2: latency from first low sample
        chk(cyc - fall_cyc == T + 3, "R2", cyc - fall_cyc, T + 3);
        obs(2'd0, 3'd0, {7'd0, bit_val});
      end
      if (rst_valid)  obs(2'd1, 3'd0, 8'd0);
      if (pres_valid) obs(2'd2, 3'd0, {7'd0, dev_present});
      if (cmd_valid)  obs(2'd3, cmd_class, cmd_byte);
    end
  end

  task automatic obs(input logic [1:0] ty, input logic [2:0] c, input logic [7:0] d);
    logic [12:0] o;
    o = {ty, c, d};
    if (oi >= en) begin
      chk(1'b0, req_of(ty), int'(o), 0);
    end else begin
      chk(o == expq[oi], req_of(expq[oi][12:11]), int'(o), int'(expq[oi]));
    end
    oi++;
  endtask

  initial begin : watchdog
    repeat (180000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", oi, en);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk({bit_valid, rst_valid, pres_valid, cmd_valid, bit_val, dev_present} == 6'd0 &&
        cmd_byte == 8'd0 && cmd_class == 3'd0, "R1",
        {bit_valid, rst_valid, pres_valid, cmd_valid, cmd_byte, cmd_class}, 0);
    repeat (5) @(negedge clk);
    chk(bit_valid == 1'b0, "R1", bit_valid, 0);

    // R8: command right after power-up reset
    send_byte(8'h33);
    // R3: boundaries at T and T+1
    slot(T, 1'b0);
    slot(T + 1, 1'b0);
    // R4 R5: exactly 8T is not a reset, 8T+1 is (no answer)
    slot(R8, 1'b0);
    slot(R8 + 1, 1'b0);
    // R6 R7: reset with presence answer, low pulse ignored
    bus_reset(1'b1);
    // R10: every listed code and unknowns
    send_byte(8'h0F); bus_reset(1'b1);
    send_byte(8'hCC); bus_reset(1'b0);
    send_byte(8'h55); bus_reset(1'b1);
    send_byte(8'hF0); bus_reset(1'b1);
    send_byte(8'h3C); bus_reset(1'b0);
    send_byte(8'h69); bus_reset(1'b1);
    send_byte(8'h00); bus_reset(1'b1);
    send_byte(8'hFF);
    // R11: trailing bits after the command
    send_byte(8'hA5);
    // R9: partial byte discarded by reset
    bus_reset(1'b1);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    bus_reset(1'b1);
    send_byte(8'h55);
    // random frames
    for (int f = 0; f < 20; f++) begin
      logic [7:0] v;
      bus_reset(1'($urandom % 2));
      case ($urandom % 8)
        0: v = 8'h33; 1: v = 8'h0F; 2: v = 8'hCC; 3: v = 8'h55;
        4: v = 8'hF0; 5: v = 8'h3C; 6: v = 8'h69;
        default: v = 8'($urandom);
      endcase
      send_byte(v);
      for (int k = 0; k < int'($urandom % 4); k++) send_bit(1'($urandom % 2));
    end
    repeat (20) @(negedge clk);
    // all expected events seen
    chk(oi == en, "R8", oi, en);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule